// File: doc/BRIEF.md
# Display Refresh Cycle-Steal Fetcher

This block is the memory-fetch half of a character display adapter that shares a read/write store with a processor. It keeps a word address into that store. A frame-start pulse loads the address with a base value, and a diagnostic switch picks that base. The address then steps through the displayed region at a rate set by the character counter. Whenever its holding register is empty, the block asks the store controller for a stolen cycle. It captures the two bytes returned during that cycle and passes them, on a separate strobe, into a character register. The video path reads that register one byte per character count.

The request is throttled by the controller's preview of the next stolen cycle. The request is dropped at once when the preview arrives, and it stays dropped until the capture has happened and one further cycle has passed. As a result, stolen cycles always alternate with processor cycles. In half-width modes each fetched word covers four character counts instead of two.

Top module: `scan_fetch`

## Requirements
- R1: While rst_n is low, fetch_addr is 0x0200, fetch_req_n is 1 (inactive) and char_byte is 0x00.
- R2: A frame_start sampled at a clock edge loads fetch_addr with 0x0000 if view_regs is 1, or with 0x0200 if view_regs is 0. It also clears the character phase to 0. frame_start takes priority over a char_tick in the same cycle.
- R3: fetch_addr only ever changes by +2 or by a reload to the base, and its bit 0 is always 0.
- R4: When half_width is 0, fetch_addr advances on every second char_tick after a frame start. When half_width is 1, it advances on every fourth. It never changes without a char_tick or a frame_start.
- R5: The address wraps to the base after the last word of its region. With view_regs=1 the step after 0x01FE gives 0x0000. With view_regs=0 the step after 0x05FE gives 0x0200.
- R6: fetch_req_n is low while the block is asking and next_steal_n is high. It goes high in the same cycle that next_steal_n goes low. It stays high until the stolen capture has completed and one further clock has passed.
- R7: rd_bus is captured into the holding register only at a clock edge where steal_n=0, mclk_a=1 and mclk_b=1. In every other case rd_bus is ignored.
- R8: A char_strobe moves the holding register into the character register and empties the holding register, so that requests resume. A char_strobe while the holding register is empty has no effect.
- R9: char_byte is the low byte (bits 7:0) or the high byte (bits 15:8) of the character register. With half_width=0, phase 0 shows the low byte and phase 1 the high byte. With half_width=1, phases 0 and 1 show the low byte and phases 2 and 3 the high byte.
- R10: fetch_req_n is high whenever the holding register is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Reload address with base, clear phase |
| view_regs | input | 1 | 1: register-view region base 0x0000; 0: normal region base 0x0200 |
| half_width | input | 1 | 1: left/right half-width mode, four counts per word |
| char_tick | input | 1 | One character count |
| next_steal_n | input | 1 | Active low: next storage cycle is stolen for the display |
| steal_n | input | 1 | Active low: current storage cycle is stolen |
| mclk_a | input | 1 | Memory clock phase A |
| mclk_b | input | 1 | Memory clock phase B |
| rd_bus | input | 16 | Storage read bus, two bytes |
| char_strobe | input | 1 | Synchronizing strobe into character register |
| fetch_addr | output | 16 | Word address into storage |
| fetch_req_n | output | 1 | Active low stolen-cycle request |
| char_byte | output | 8 | Byte currently presented to the video path |

## Verification
The case that is hardest to reach from the ports is the wrap at the end of each region. It needs hundreds of character counts with no frame start in between. The bench drives 512 and 1024 consecutive ticks in the two views and compares every address against its own running model. A second subtle case is a capture that arrives while the block is asking without having seen the preview. The bench delivers that capture with next_steal_n held high and confirms that the request drops for as long as the holding register stays full.

// File: rtl/scan_fetch_pkg.sv
package scan_fetch_pkg;
  typedef enum logic [1:0] {
    REQ_IDLE,
    REQ_ASK,
    REQ_WAIT,
    REQ_REST
  } req_state_t;
endpackage

// File: rtl/scan_fetch_addr.sv
module scan_fetch_addr #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_BASE  = 'h0000,
  parameter logic [ADDR_W-1:0] REG_END   = 'h01FF,
  parameter logic [ADDR_W-1:0] NORM_BASE = 'h0200,
  parameter logic [ADDR_W-1:0] NORM_END  = 'h05FF,
  parameter int FULL_SPAN = 2,
  parameter int HALF_SPAN = 4,
  localparam int PH_W = $clog2(HALF_SPAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              view_regs,
  input  logic              half_width,
  input  logic              char_tick,
  output logic [ADDR_W-1:0] addr,
  output logic [PH_W-1:0]   phase,
  output logic              adv_evt,
  output logic              reload_evt
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] EVEN_MASK = ~ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] region_base(input logic regs);
    return regs ? REG_BASE : NORM_BASE;
  endfunction

  function automatic logic [ADDR_W-1:0] region_last(input logic regs);
    return (regs ? REG_END : NORM_END) & EVEN_MASK;
  endfunction

  function automatic logic [ADDR_W-1:0] word_step(input logic [ADDR_W-1:0] a,
                                                  input logic regs);
    return (a >= region_last(regs)) ? region_base(regs) : a + WORD_STEP;
  endfunction

  function automatic logic [PH_W-1:0] phase_top(input logic half);
    return half ? PH_W'(HALF_SPAN - 1) : PH_W'(FULL_SPAN - 1);
  endfunction

  assign reload_evt = frame_start;
  assign adv_evt    = !frame_start && char_tick && (phase >= phase_top(half_width));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= NORM_BASE;
      phase <= '0;
    end else if (reload_evt) begin
      addr  <= region_base(view_regs);
      phase <= '0;
    end else if (adv_evt) begin
      addr  <= word_step(addr, view_regs);
      phase <= '0;
    end else if (char_tick) begin
      phase <= phase + PH_W'(1);
    end
  end
endmodule

// File: rtl/scan_fetch_buf.sv
module scan_fetch_buf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              steal_n,
  input  logic              mclk_a,
  input  logic              mclk_b,
  input  logic [DATA_W-1:0] rd_bus,
  input  logic              char_strobe,
  output logic              buf_full,
  output logic [DATA_W-1:0] char_word,
  output logic              cap_evt,
  output logic              xfer_evt
);
  logic [DATA_W-1:0] hold_word;

  assign cap_evt  = !steal_n && mclk_a && mclk_b;
  assign xfer_evt = char_strobe && buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      char_word <= '0;
      buf_full  <= 1'b0;
    end else begin
      if (xfer_evt) char_word <= hold_word;
      if (cap_evt) begin
        hold_word <= rd_bus;
        buf_full  <= 1'b1;
      end else if (xfer_evt) begin
        buf_full  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/scan_fetch_req.sv
module scan_fetch_req
  import scan_fetch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic buf_full,
  input  logic cap_evt,
  input  logic next_steal_n,
  output logic fetch_req_n
);
  req_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      REQ_IDLE: if (!buf_full) state_nx = REQ_ASK;
      REQ_ASK: begin
        if (!next_steal_n)  state_nx = REQ_WAIT;
        else if (buf_full)  state_nx = REQ_IDLE;
      end
      REQ_WAIT: if (cap_evt) state_nx = REQ_REST;
      REQ_REST: state_nx = REQ_IDLE;
      default:  state_nx = REQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= REQ_IDLE;
    else        state <= state_nx;
  end

  assign fetch_req_n = !((state == REQ_ASK) && next_steal_n && !buf_full);
endmodule

// File: rtl/scan_fetch.sv
module scan_fetch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] REG_BASE  = 'h0000,
  parameter logic [ADDR_W-1:0] REG_END   = 'h01FF,
  parameter logic [ADDR_W-1:0] NORM_BASE = 'h0200,
  parameter logic [ADDR_W-1:0] NORM_END  = 'h05FF,
  parameter int FULL_SPAN = 2,
  parameter int HALF_SPAN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 view_regs,
  input  logic                 half_width,
  input  logic                 char_tick,
  input  logic                 next_steal_n,
  input  logic                 steal_n,
  input  logic                 mclk_a,
  input  logic                 mclk_b,
  input  logic [DATA_W-1:0]    rd_bus,
  input  logic                 char_strobe,
  output logic [ADDR_W-1:0]    fetch_addr,
  output logic                 fetch_req_n,
  output logic [DATA_W/2-1:0]  char_byte
);
  localparam int CHAR_W = DATA_W / 2;
  localparam int PH_W   = $clog2(HALF_SPAN);

  logic [PH_W-1:0]   phase;
  logic              adv_evt, reload_evt;
  logic              buf_full, cap_evt, xfer_evt;
  logic [DATA_W-1:0] char_word;

  function automatic logic pick_high(input logic [PH_W-1:0] ph, input logic half);
    return half ? (ph >= PH_W'(HALF_SPAN / 2)) : (ph >= PH_W'(FULL_SPAN / 2));
  endfunction

  scan_fetch_addr #(
    .ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .REG_END(REG_END),
    .NORM_BASE(NORM_BASE), .NORM_END(NORM_END),
    .FULL_SPAN(FULL_SPAN), .HALF_SPAN(HALF_SPAN)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .view_regs(view_regs),
    .half_width(half_width), .char_tick(char_tick), .addr(fetch_addr),
    .phase(phase), .adv_evt(adv_evt), .reload_evt(reload_evt)
  );

  scan_fetch_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .steal_n(steal_n), .mclk_a(mclk_a), .mclk_b(mclk_b),
    .rd_bus(rd_bus), .char_strobe(char_strobe), .buf_full(buf_full),
    .char_word(char_word), .cap_evt(cap_evt), .xfer_evt(xfer_evt)
  );

  scan_fetch_req u_req (
    .clk(clk), .rst_n(rst_n), .buf_full(buf_full), .cap_evt(cap_evt),
    .next_steal_n(next_steal_n), .fetch_req_n(fetch_req_n)
  );

  assign char_byte = pick_high(phase, half_width) ? char_word[DATA_W-1:CHAR_W]
                                                  : char_word[CHAR_W-1:0];
endmodule

// File: rtl/scan_fetch_chk.sv
module scan_fetch_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_BASE  = 'h0000,
  parameter logic [ADDR_W-1:0] NORM_BASE = 'h0200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              view_regs,
  input logic              char_tick,
  input logic              next_steal_n,
  input logic              steal_n,
  input logic              mclk_a,
  input logic              mclk_b,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_req_n,
  input logic              buf_full
);
  assert_even_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr[0] == 1'b0);

  assert_hold_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!char_tick && !frame_start) |=> $stable(fetch_addr));

  assert_frame_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (fetch_addr == ($past(view_regs) ? REG_BASE : NORM_BASE)));

  assert_preview_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !next_steal_n |-> fetch_req_n);

  assert_full_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> fetch_req_n);

  assert_gated_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> $past(!steal_n && mclk_a && mclk_b));
endmodule

bind scan_fetch scan_fetch_chk #(
  .ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .NORM_BASE(NORM_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .view_regs(view_regs),
  .char_tick(char_tick), .next_steal_n(next_steal_n), .steal_n(steal_n),
  .mclk_a(mclk_a), .mclk_b(mclk_b), .fetch_addr(fetch_addr),
  .fetch_req_n(fetch_req_n), .buf_full(buf_full)
);

// File: tb/scan_fetch_test.sv
`timescale 1ns/1ps
module scan_fetch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0, view_regs = 1'b0, half_width = 1'b0, char_tick = 1'b0;
  logic        next_steal_n = 1'b1, steal_n = 1'b1, mclk_a = 1'b0, mclk_b = 1'b0;
  logic [15:0] rd_bus = '0;
  logic        char_strobe = 1'b0;
  logic [15:0] fetch_addr;
  logic        fetch_req_n;
  logic [7:0]  char_byte;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  scan_fetch uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .view_regs(view_regs),
    .half_width(half_width), .char_tick(char_tick), .next_steal_n(next_steal_n),
    .steal_n(steal_n), .mclk_a(mclk_a), .mclk_b(mclk_b), .rd_bus(rd_bus),
    .char_strobe(char_strobe), .fetch_addr(fetch_addr), .fetch_req_n(fetch_req_n),
    .char_byte(char_byte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick();
    char_tick = 1'b1; step(); char_tick = 1'b0;
  endtask

  task automatic frame(input logic regs, input logic half);
    view_regs = regs; half_width = half;
    frame_start = 1'b1; step(); frame_start = 1'b0;
  endtask

  task automatic capture(input logic [15:0] w);
    steal_n = 1'b0; mclk_a = 1'b1; mclk_b = 1'b1; rd_bus = w;
    step();
    steal_n = 1'b1; mclk_a = 1'b0; mclk_b = 1'b0; rd_bus = '0;
  endtask

  task automatic strobe();
    char_strobe = 1'b1; step(); char_strobe = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) step();
    chk("R1 addr", fetch_addr, 16'h0200);
    chk("R1 req", fetch_req_n, 1'b1);
    chk("R1 byte", char_byte, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R6 ask after reset", fetch_req_n, 1'b0);
  endtask

  task automatic t_handshake();
    frame(1'b0, 1'b0);
    next_steal_n = 1'b0; #1;
    chk("R6 preview drops req", fetch_req_n, 1'b1);
    step(); next_steal_n = 1'b1; #1;
    chk("R6 held while waiting", fetch_req_n, 1'b1);
    capture(16'hA55A);
    chk("R10 full quiet", fetch_req_n, 1'b1);
    step();
    chk("R6 rest cycle", fetch_req_n, 1'b1);
    step();
    chk("R10 still full", fetch_req_n, 1'b1);
    strobe();
    chk("R8 transfer low byte", char_byte, 8'h5A);
    chk("R8 idle after transfer", fetch_req_n, 1'b1);
    step();
    chk("R8 request resumes", fetch_req_n, 1'b0);
  endtask

  task automatic t_ignore();
    strobe();
    chk("R8 empty strobe", char_byte, 8'h5A);
    steal_n = 1'b0; mclk_a = 1'b1; mclk_b = 1'b0; rd_bus = 16'h1111; step();
    steal_n = 1'b1; mclk_a = 1'b1; mclk_b = 1'b1; rd_bus = 16'h2222; step();
    steal_n = 1'b0; mclk_a = 1'b0; mclk_b = 1'b1; rd_bus = 16'h3333; step();
    steal_n = 1'b1; mclk_a = 1'b0; mclk_b = 1'b0; rd_bus = '0;
    chk("R7 no capture keeps req", fetch_req_n, 1'b0);
    strobe();
    chk("R7 bus ignored", char_byte, 8'h5A);
    capture(16'hC33C);
    chk("R10 capture without preview", fetch_req_n, 1'b1);
    strobe();
    chk("R7 gated capture", char_byte, 8'h3C);
  endtask

  task automatic t_rate();
    frame(1'b0, 1'b0);
    chk("R2 normal base", fetch_addr, 16'h0200);
    chk("R9 full ph0", char_byte, 8'h3C);
    tick();
    chk("R4 full hold", fetch_addr, 16'h0200);
    chk("R9 full ph1", char_byte, 8'hC3);
    tick();
    chk("R4 full step", fetch_addr, 16'h0202);
    chk("R9 full wrap ph0", char_byte, 8'h3C);
    frame(1'b0, 1'b1);
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk("R4 half addr", fetch_addr, (k == 4) ? 16'h0202 : 16'h0200);
      chk("R9 half byte", char_byte, (k == 4) ? 8'h3C : ((k >= 2) ? 8'hC3 : 8'h3C));
    end
    frame(1'b1, 1'b0);
    chk("R2 regs base", fetch_addr, 16'h0000);
    tick();
    char_tick = 1'b1; frame_start = 1'b1; view_regs = 1'b0; step();
    char_tick = 1'b0; frame_start = 1'b0;
    chk("R2 priority base", fetch_addr, 16'h0200);
    tick();
    chk("R2 phase cleared", fetch_addr, 16'h0200);
  endtask

  task automatic t_wrap(input logic regs, input logic [15:0] base, input int words);
    logic [15:0] exp;
    frame(regs, 1'b0);
    exp = base;
    for (int w = 0; w < words; w++) begin
      tick(); tick();
      exp = (w == words - 1) ? base : exp + 16'd2;
      chk("R3 R5 walk", fetch_addr, exp);
      if (w == words - 2) chk("R5 last word", fetch_addr, base + 16'(2 * (words - 1)));
    end
    chk("R5 wrapped", fetch_addr, base);
  endtask

  task automatic done();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    done();
  end

  initial begin
    t_reset();
    t_handshake();
    t_ignore();
    t_rate();
    t_wrap(1'b1, 16'h0000, 256);
    t_wrap(1'b0, 16'h0200, 512);
    done();
  end
endmodule